// File: doc/BRIEF.md
# Reset and Exception Vector Sequencer

This block stands between the reset sources of a processor and its instruction fetch logic. There are three reset sources. The first is an external active-low pin, which must stay low for a minimum time before it counts. The second is a watchdog overflow pulse and the third is a pulse on exit from deep standby. All three lead into one common reset sequence. That sequence puts the architectural control state back to its reset values. It then reads the reset vector from a synchronous memory port, loads the program counter and signals the fetch logic to start.

Ordinary exception requests also pass through this block. Each request carries a vector offset and a source kind. Address-error requests index the vector table directly. All other requests are offset from a software-writable vector base register. While any sequence is running, the `busy` output stalls the core. New exception requests wait until the program counter has been loaded. A reset takes over at any moment and abandons whatever sequence was running.

Top module: `rv_sequencer`

## Requirements
- R1: After a two-flop synchronizer, the reset pin counts as a reset only once it has been low for MIN_LOW (default 20) consecutive synchronized cycles. A pin pulse of MIN_LOW-1 synchronized cycles has no effect on any output.
- R2: During a reset, `busy` is 1 and `memReq` is 0. The vector fetch begins only after every reset source has deasserted: the pin has gone high after qualifying, and the watchdog and standby-exit pulses have ended.
- R3: A reset source arriving during an exception sequence abandons it. A memory response that arrives after the abort does not load the PC, and the reset vector is fetched instead.
- R4: A reset sets the following values. `vbrOut` = 0, `exrT` = 0, `exrI` = 3'b111, `ccrI` = 1, `intMode` = 0, `alignErr` = 0. These are also the values after `porN`.
- R5: The vector address is chosen by request type. For a reset it is RESET_VEC (default 0). For an address-error request (`excKind`=1) it is the offset alone. For any other request (`excKind`=0) it is `vbrOut` + offset.
- R6: `memReq` is high for exactly one cycle per fetch. The `memRdata` present while `memValid` is high in the cycle after the request is loaded into `pcOut`.
- R7: `fetchStart` is a single-cycle pulse in the cycle after `pcOut` is loaded. `busy` drops in the cycle that follows it.
- R8: An offset has its two low bits forced to zero. `alignErr` is set when those bits were nonzero, and it keeps that value until the next accepted request or the next reset.
- R9: A request is accepted only when the block is idle and no reset source is active. `excAck` pulses in the accepting cycle. A request held high while busy is accepted again one cycle after `fetchStart`, so there is one acceptance every 4 cycles.
- R10: `vbrWe` writes `vbrWdata` with its two low bits cleared. `statWe` writes `statWdata`, with bit 0 going to `exrT`, bits 3:1 to `exrI`, bit 4 to `ccrI` and bits 6:5 to `intMode`. Both writes are ignored while a reset is being applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset of the block's flops, active low |
| resPinN | input | 1 | External reset pin, active low, asynchronous |
| wdtOvf | input | 1 | Watchdog overflow reset pulse |
| dstbyExit | input | 1 | Deep-standby exit reset pulse |
| excReq | input | 1 | Exception request, held until acknowledged |
| excOffset | input | OFF_W | Vector table offset of the request |
| excKind | input | 1 | 1 = address error (raw offset), 0 = base-relative |
| excAck | output | 1 | Request accepted this cycle |
| vbrWe | input | 1 | Vector base register write enable |
| vbrWdata | input | ADDR_W | Vector base write data |
| statWe | input | 1 | Status write enable |
| statWdata | input | 7 | Status write data (layout in R10) |
| memReq | output | 1 | Vector read request |
| memAddr | output | ADDR_W | Vector read address |
| memRdata | input | 32 | Vector read data |
| memValid | input | 1 | Read data valid |
| busy | output | 1 | Sequence in progress, core stalled |
| pcOut | output | 32 | Program counter |
| fetchStart | output | 1 | Fetch may begin at `pcOut` |
| vbrOut | output | ADDR_W | Vector base register |
| exrT | output | 1 | Trace bit of the extended status |
| exrI | output | 3 | Interrupt mask of the extended status |
| ccrI | output | 1 | Interrupt mask of the condition code |
| intMode | output | 2 | Interrupt control mode |
| alignErr | output | 1 | Last offset was misaligned |

## Verification
The case that is hardest to reach is a reset landing on a sequence that already has a memory response in flight. The read data then arrives after the abort, and it must be dropped rather than loaded into the PC. The stimulus starts a base-relative exception and raises the watchdog pulse on the very next edge, which catches the block while it waits for data. A separate pin pulse exactly one cycle short of qualification checks the boundary of the low-time filter.

// File: rtl/rv_pkg.sv
package rv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_REQ,
    ST_WAIT,
    ST_START
  } rvState_e;

  typedef struct packed {
    logic init;
    logic latchReset;
    logic latchExc;
    logic loadPc;
  } rvStrobe_t;

  typedef struct packed {
    logic [1:0] intMode;
    logic       ccrI;
    logic [2:0] exrI;
    logic       exrT;
  } rvStat_t;

  localparam rvStat_t STAT_RESET = '{intMode: 2'd0, ccrI: 1'b1, exrI: 3'b111, exrT: 1'b0};
endpackage

// File: rtl/rv_ctrl.sv
module rv_ctrl
  import rv_pkg::*;
#(
  parameter int MIN_LOW = 20
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      resPinN,
  input  logic      wdtOvf,
  input  logic      dstbyExit,
  input  logic      excReq,
  input  logic      memValid,
  output logic      excAck,
  output logic      busy,
  output logic      memReq,
  output logic      fetchStart,
  output rvStrobe_t strobe
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic pinMeta, pinSync;
  logic [CNT_W-1:0] lowCnt;
  logic qualified, resetReq;
  rvState_e state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pinMeta <= 1'b1;
      pinSync <= 1'b1;
    end else begin
      pinMeta <= resPinN;
      pinSync <= pinMeta;
    end
  end

  assign qualified = (lowCnt == CNT_W'(MIN_LOW));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          lowCnt <= '0;
    else if (pinSync)   lowCnt <= '0;
    else if (!qualified) lowCnt <= lowCnt + 1'b1;
  end

  assign resetReq = qualified | wdtOvf | dstbyExit;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    excAck    = 1'b0;
    strobe.init = (state == ST_HOLD);
    if (resetReq) begin
      stateNext = ST_HOLD;
    end else begin
      case (state)
        ST_IDLE: if (excReq) begin
          stateNext       = ST_REQ;
          strobe.latchExc = 1'b1;
          excAck          = 1'b1;
        end
        ST_HOLD: begin
          stateNext         = ST_REQ;
          strobe.latchReset = 1'b1;
        end
        ST_REQ:  stateNext = ST_WAIT;
        ST_WAIT: if (memValid) begin
          stateNext     = ST_START;
          strobe.loadPc = 1'b1;
        end
        ST_START: stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy       = (state != ST_IDLE);
  assign memReq     = (state == ST_REQ);
  assign fetchStart = (state == ST_START);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!porN)
    memReq |=> !memReq);
  assert_reset_hold_R3: assert property (@(posedge clk) disable iff (!porN)
    resetReq |=> (busy && !memReq && !fetchStart));
  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!porN)
    excAck |=> (busy && memReq));
  assert_fetch_once_R7: assert property (@(posedge clk) disable iff (!porN)
    fetchStart |=> (!fetchStart && !busy));
  assert_short_low_R1: assert property (@(posedge clk) disable iff (!porN)
    ($rose(qualified)) |-> !pinSync);
endmodule

// File: rtl/rv_datapath.sv
module rv_datapath
  import rv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 10,
  parameter int RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              porN,
  input  rvStrobe_t         strobe,
  input  logic [OFF_W-1:0]  excOffset,
  input  logic              excKind,
  input  logic              vbrWe,
  input  logic [ADDR_W-1:0] vbrWdata,
  input  logic              statWe,
  input  rvStat_t           statWdata,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       pc,
  output logic [ADDR_W-1:0] vbr,
  output rvStat_t           stat,
  output logic              alignErr
);
  localparam int PAD_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] curOff;
  logic             curRaw;
  logic [ADDR_W-1:0] offExt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      vbr  <= '0;
      stat <= STAT_RESET;
    end else if (strobe.init) begin
      vbr  <= '0;
      stat <= STAT_RESET;
    end else begin
      if (vbrWe)  vbr  <= {vbrWdata[ADDR_W-1:2], 2'b00};
      if (statWe) stat <= statWdata;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      curOff   <= '0;
      curRaw   <= 1'b1;
      alignErr <= 1'b0;
    end else begin
      if (strobe.init) alignErr <= 1'b0;
      if (strobe.latchReset) begin
        curOff <= OFF_W'(RESET_VEC);
        curRaw <= 1'b1;
      end else if (strobe.latchExc) begin
        curOff   <= {excOffset[OFF_W-1:2], 2'b00};
        curRaw   <= excKind;
        alignErr <= |excOffset[1:0];
      end
    end
  end

  assign offExt  = {{PAD_W{1'b0}}, curOff};
  assign memAddr = curRaw ? offExt : (vbr + offExt);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             pc <= '0;
    else if (strobe.loadPc) pc <= memRdata;
  end

  assert_init_values_R4: assert property (@(posedge clk) disable iff (!porN)
    strobe.init |=> (vbr == '0 && stat == STAT_RESET && !alignErr));
  assert_pc_load_R6: assert property (@(posedge clk) disable iff (!porN)
    strobe.loadPc |=> (pc == $past(memRdata)));
  assert_reset_raw_R5: assert property (@(posedge clk) disable iff (!porN)
    strobe.latchReset |=> (memAddr == ADDR_W'(RESET_VEC)));
  assert_vbr_aligned_R10: assert property (@(posedge clk) disable iff (!porN)
    vbrWe && !strobe.init |=> (vbr[1:0] == 2'b00));
endmodule

// File: rtl/rv_sequencer.sv
module rv_sequencer
  import rv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 10,
  parameter int MIN_LOW   = 20,
  parameter int RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              resPinN,
  input  logic              wdtOvf,
  input  logic              dstbyExit,
  input  logic              excReq,
  input  logic [OFF_W-1:0]  excOffset,
  input  logic              excKind,
  output logic              excAck,
  input  logic              vbrWe,
  input  logic [ADDR_W-1:0] vbrWdata,
  input  logic              statWe,
  input  logic [6:0]        statWdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdata,
  input  logic              memValid,
  output logic              busy,
  output logic [31:0]       pcOut,
  output logic              fetchStart,
  output logic [ADDR_W-1:0] vbrOut,
  output logic              exrT,
  output logic [2:0]        exrI,
  output logic              ccrI,
  output logic [1:0]        intMode,
  output logic              alignErr
);
  rvStrobe_t strobe;
  rvStat_t   statQ;

  rv_ctrl #(.MIN_LOW(MIN_LOW)) ctrl_i (
    .clk(clk), .porN(porN), .resPinN(resPinN), .wdtOvf(wdtOvf),
    .dstbyExit(dstbyExit), .excReq(excReq), .memValid(memValid),
    .excAck(excAck), .busy(busy), .memReq(memReq),
    .fetchStart(fetchStart), .strobe(strobe)
  );

  rv_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RESET_VEC(RESET_VEC)) dp_i (
    .clk(clk), .porN(porN), .strobe(strobe), .excOffset(excOffset),
    .excKind(excKind), .vbrWe(vbrWe), .vbrWdata(vbrWdata),
    .statWe(statWe), .statWdata(rvStat_t'(statWdata)), .memRdata(memRdata),
    .memAddr(memAddr), .pc(pcOut), .vbr(vbrOut), .stat(statQ),
    .alignErr(alignErr)
  );

  assign exrT    = statQ.exrT;
  assign exrI    = statQ.exrI;
  assign ccrI    = statQ.ccrI;
  assign intMode = statQ.intMode;
endmodule

// File: tb/rv_sequencer_tb_top.sv
module rv_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 20;
  localparam int OFF_W      = 10;

  logic clk = 1'b0;
  logic porN = 1'b0, resPinN = 1'b1, wdtOvf = 1'b0, dstbyExit = 1'b0;
  logic excReq = 1'b0, excKind = 1'b0, vbrWe = 1'b0, statWe = 1'b0;
  logic [OFF_W-1:0] excOffset = '0;
  logic [31:0] vbrWdata = '0;
  logic [6:0]  statWdata = '0;
  logic memValid = 1'b0;
  logic [31:0] memRdata = '0;
  logic excAck, memReq, busy, fetchStart, exrT, ccrI, alignErr;
  logic [31:0] memAddr, pcOut, vbrOut;
  logic [2:0] exrI;
  logic [1:0] intMode;

  int checks = 0, fails = 0;
  bit running = 1'b0;

  rv_sequencer #(.OFF_W(OFF_W), .MIN_LOW(MIN_LOW)) dut_i (
    .clk(clk), .porN(porN), .resPinN(resPinN), .wdtOvf(wdtOvf),
    .dstbyExit(dstbyExit), .excReq(excReq), .excOffset(excOffset),
    .excKind(excKind), .excAck(excAck), .vbrWe(vbrWe), .vbrWdata(vbrWdata),
    .statWe(statWe), .statWdata(statWdata), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata), .memValid(memValid), .busy(busy), .pcOut(pcOut),
    .fetchStart(fetchStart), .vbrOut(vbrOut), .exrT(exrT), .exrI(exrI),
    .ccrI(ccrI), .intMode(intMode), .alignErr(alignErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  always @(posedge clk) begin
    memValid <= memReq;
    memRdata <= memFn(memAddr);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph, m_cnt;
  bit m_s1, m_s2, m_raw, m_align;
  logic [31:0] m_off, m_pc, m_vbr;
  logic [6:0]  m_stat;

  always @(posedge clk) begin
    bit rr;
    int nph;
    if (!porN) begin
      m_s1 = 1; m_s2 = 1; m_cnt = 0; m_ph = 0; m_off = 0; m_raw = 1;
      m_pc = 0; m_vbr = 0; m_stat = 7'h1E; m_align = 0;
    end else begin
      rr  = (m_cnt == MIN_LOW) || wdtOvf || dstbyExit;
      nph = m_ph;
      if (rr) nph = 1;
      else case (m_ph)
        0: if (excReq) begin
             nph = 2; m_off = {22'd0, excOffset} & ~32'd3;
             m_raw = excKind; m_align = (excOffset % 4) != 0;
           end
        1: begin nph = 2; m_off = 0; m_raw = 1; end
        2: nph = 3;
        3: if (memValid) begin m_pc = memRdata; nph = 4; end
        default: nph = 0;
      endcase
      if (m_ph == 1) begin
        m_vbr = 0; m_stat = 7'h1E; m_align = 0;
      end else begin
        if (vbrWe)  m_vbr  = vbrWdata & ~32'd3;
        if (statWe) m_stat = statWdata;
      end
      if (m_s2) m_cnt = 0;
      else if (m_cnt < MIN_LOW) m_cnt++;
      m_s2 = m_s1; m_s1 = resPinN;
      m_ph = nph;
    end
  end

  always @(negedge clk) begin
    if (running && porN) begin
      bit rrNow;
      rrNow = (m_cnt == MIN_LOW) || wdtOvf || dstbyExit;
      chk("R2 busy", busy, m_ph != 0);
      chk("R6 memReq", memReq, m_ph == 2);
      chk("R7 fetchStart", fetchStart, m_ph == 4);
      chk("R9 excAck", excAck, (m_ph == 0) && excReq && !rrNow);
      chk("R5 memAddr", memAddr, m_raw ? m_off : m_vbr + m_off);
      chk("R6 pcOut", pcOut, m_pc);
      chk("R10 vbrOut", vbrOut, m_vbr);
      chk("R4 status", {intMode, ccrI, exrI, exrT}, m_stat);
      chk("R8 alignErr", alignErr, m_align);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doExc(input logic [OFF_W-1:0] off, input bit kind);
    excReq = 1'b1; excOffset = off; excKind = kind;
    step(1);
    excReq = 1'b0;
    step(4);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int acks;
    step(3);
    porN = 1'b1;
    running = 1'b1;
    step(1);
    // R4: values after power-on
    chk("R4 reset vbr", vbrOut, 0);
    chk("R4 reset exrI", exrI, 3'b111);
    chk("R4 reset ccrI", ccrI, 1);
    chk("R4 reset exrT", exrT, 0);
    chk("R4 reset intMode", intMode, 0);

    // R10: writes, low VBR bits cleared
    vbrWe = 1; vbrWdata = 32'h1000_0003; statWe = 1; statWdata = 7'b1000001;
    step(1);
    vbrWe = 0; statWe = 0;
    chk("R10 vbr write", vbrOut, 32'h1000_0000);
    chk("R10 stat write", {intMode, ccrI, exrI, exrT}, 7'b1000001);

    // R5/R6/R7: base-relative and raw
    doExc(10'h040, 1'b0);
    chk("R5 base-relative pc", pcOut, memFn(32'h1000_0040));
    doExc(10'h024, 1'b1);
    chk("R5 address-error raw pc", pcOut, memFn(32'h0000_0024));

    // R8: misaligned offset
    doExc(10'h02B, 1'b0);
    chk("R8 aligned pc", pcOut, memFn(32'h1000_0028));
    chk("R8 flag set", alignErr, 1);
    doExc(10'h030, 1'b0);
    chk("R8 flag cleared", alignErr, 0);

    // R9: request held high through busy
    excReq = 1; excOffset = 10'h010; excKind = 0;
    acks = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (excAck) acks++;
    end
    @(posedge clk); #1;
    excReq = 0;
    step(4);
    chk("R9 acceptances in window", acks, 3);

    // R1: one cycle short of qualification
    resPinN = 0; step(MIN_LOW - 1);
    resPinN = 1; step(6);
    chk("R1 short pulse vbr kept", vbrOut, 32'h1000_0000);
    chk("R1 short pulse stat kept", {intMode, ccrI, exrI, exrT}, 7'b1000001);

    // R1/R2/R4: qualified pin reset
    resPinN = 0; step(MIN_LOW + 6);
    chk("R2 busy while pin low", busy, 1);
    chk("R2 no fetch while pin low", memReq, 0);
    chk("R4 vbr cleared", vbrOut, 0);
    chk("R4 exrI set", exrI, 3'b111);
    resPinN = 1; step(10);
    chk("R2 reset vector pc", pcOut, memFn(32'h0));
    chk("R2 idle after reset", busy, 0);

    // R3: watchdog aborts an exception waiting for data
    vbrWe = 1; vbrWdata = 32'h2000_0000; step(1); vbrWe = 0;
    doExc(10'h080, 1'b0);
    chk("R5 new base pc", pcOut, memFn(32'h2000_0080));
    vbrWe = 1; vbrWdata = 32'h3000_0000; step(1); vbrWe = 0;
    excReq = 1; excOffset = 10'h044; excKind = 0;
    step(1);
    excReq = 0;
    wdtOvf = 1; step(3);
    chk("R3 pc untouched during abort", pcOut, memFn(32'h2000_0080));
    wdtOvf = 0; step(6);
    chk("R3 reset vector after abort", pcOut, memFn(32'h0));
    chk("R3 vbr cleared", vbrOut, 0);

    // R2: standby exit pulse
    doExc(10'h0C0, 1'b1);
    dstbyExit = 1; step(2);
    chk("R2 busy during standby pulse", busy, 1);
    dstbyExit = 0; step(6);
    chk("R2 standby reset pc", pcOut, memFn(32'h0));
    step(2);
    running = 1'b0;
    finishRun();
  end
endmodule